// File: doc/BRIEF.md
# Destructive-Read Rewind Buffer

This block sits between a PCI target core's read data path and a local source FIFO whose reads are destructive: once a dword leaves the FIFO, it is gone. The block pulls dwords from that source into a small private buffer and hands them to the core one at a time. A dword goes to the core only when the core raises its address-increment strobe while the block is raising ready.

A PCI target core fetches ahead, so at the end of a transaction up to two dwords may sit in the core's read pipeline without ever reaching the host. On the cycle the core flags as the final transfer, the block reads the core's 2-bit pipeline occupancy code. It moves its delivery pointer back by that many dwords, so they are presented again first in the next read, and it releases only the dwords that the host really consumed. While nothing is ready, the block inserts wait states. When a transfer is requested and there is no data in the buffer or in the source, it asks the core to disconnect.

Top module: `np_read_rewind`

## Requirements
- R1: After reset, `core_rdy`, `core_stop` and `occ_err` are low, and `src_pop` is low while `src_valid` is low.
- R2: `src_pop` is high exactly when `src_valid` is high and the buffer holds fewer than DEPTH dwords. Dwords delivered to the core still count as held until the end of their transaction.
- R3: `core_rdata` presents the held dwords in arrival order. The block moves to the next dword only on a cycle where `core_inc` and `core_rdy` are both high.
- R4: `core_rdy` is high exactly when at least one held dword has not yet been handed to the core in the current transaction.
- R5: On a cycle with `core_last` high, the occupancy code 2'b00, 2'b01 or 2'b11 moves delivery back by 0, 1 or 2 dwords. A transfer on that same cycle counts first. The rewound dwords are the next ones presented, and every dword before them is released.
- R6: Occupancy code 2'b10 on a `core_last` cycle is illegal. It raises `occ_err` for exactly the following cycle and rewinds nothing. `occ_err` is low at all other times.
- R7: `core_stop` is high exactly when `core_inc` is high, no undelivered dword is held, and `src_valid` is low.
- R8: While `core_rdy` is high and `core_inc` and `core_last` are low, the next cycle keeps `core_rdy` high and keeps `core_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source FIFO has a dword at its head |
| src_data | input | W | Head dword of the source FIFO (show-ahead) |
| src_pop | output | 1 | Take the head dword from the source FIFO |
| core_inc | input | 1 | Core is ready to take a read dword |
| core_last | input | 1 | Final transfer of the transaction |
| core_occ | input | 2 | Dwords held in the core's read pipeline |
| core_rdata | output | W | Read dword offered to the core |
| core_rdy | output | 1 | Offered dword is valid |
| core_stop | output | 1 | Request a disconnect of the access |
| occ_err | output | 1 | Illegal occupancy code seen on the last cycle |

## Verification
The assertions assume that the core never reports more dwords in its pipeline than it took during the current transaction, counting a transfer on the last cycle. They also assume that the source FIFO holds its head dword steady until it is popped. The stimulus keeps to both. It drives a source modelled as a queue, and it chooses each last-cycle occupancy code only after at least that many transfers have occurred since the previous last cycle. Wait-state gaps, a completely drained source, a full buffer and the illegal code are each driven deliberately.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

   typedef enum logic [1:0] {
      OCC_NONE = 2'b00,
      OCC_ONE  = 2'b01,
      OCC_BAD  = 2'b10,
      OCC_TWO  = 2'b11
   } occ_code_e;

endpackage

// File: rtl/rpr_occ_decode.sv
module rpr_occ_decode
   import rpr_pkg::*;
(
   input  logic       last_i,
   input  logic [1:0] code_i,
   output logic [1:0] back_o,
   output logic       bad_o
);
   occ_code_e code;
   assign code = occ_code_e'(code_i);

   always_comb begin
      back_o = 2'd0;
      bad_o  = 1'b0;
      if (last_i) begin
         unique case (code)
            OCC_NONE: back_o = 2'd0;
            OCC_ONE:  back_o = 2'd1;
            OCC_TWO:  back_o = 2'd2;
            OCC_BAD:  bad_o  = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/rpr_store.sv
module rpr_store #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rpr_ptr_ctrl.sv
module rpr_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_valid_i,
   input  logic          inc_i,
   input  logic          last_i,
   input  logic [1:0]    back_i,
   output logic          push_o,
   output logic [AW-1:0] waddr_o,
   output logic [AW-1:0] raddr_o,
   output logic          rdy_o,
   output logic          stop_o
);
   logic [PW-1:0] wr_q, rd_q, cm_q;
   logic [PW-1:0] held, rd_adv, rd_back;
   logic          unread, full, xfer;

   assign unread  = (wr_q != rd_q);
   assign held    = wr_q - cm_q;
   assign full    = (held == PW'(DEPTH));
   assign xfer    = inc_i & unread;
   assign rd_adv  = rd_q + PW'(xfer);
   assign rd_back = rd_adv - PW'(back_i);

   assign push_o  = src_valid_i & ~full;
   assign rdy_o   = unread;
   assign stop_o  = inc_i & ~unread & ~src_valid_i;
   assign waddr_o = wr_q[AW-1:0];
   assign raddr_o = rd_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
         cm_q <= '0;
      end else begin
         if (push_o) wr_q <= wr_q + PW'(1);
         if (last_i) begin
            rd_q <= rd_back;
            cm_q <= rd_back;
         end else begin
            rd_q <= rd_adv;
         end
      end
   end
endmodule

// File: rtl/np_read_rewind.sv
module np_read_rewind #(
   parameter int W     = 32,
   parameter int DEPTH = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         src_valid,
   input  logic [W-1:0] src_data,
   output logic         src_pop,
   input  logic         core_inc,
   input  logic         core_last,
   input  logic [1:0]   core_occ,
   output logic [W-1:0] core_rdata,
   output logic         core_rdy,
   output logic         core_stop,
   output logic         occ_err
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("np_read_rewind: DEPTH must be a power of two, at least 4");
      end
      if (W < 1) begin : g_bad_width
         $error("np_read_rewind: W must be positive");
      end
   endgenerate

   logic [1:0]    back;
   logic          bad;
   logic          push;
   logic [AW-1:0] waddr, raddr;

   rpr_occ_decode u_dec (
      .last_i (core_last),
      .code_i (core_occ),
      .back_o (back),
      .bad_o  (bad)
   );

   rpr_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_valid_i (src_valid),
      .inc_i       (core_inc),
      .last_i      (core_last),
      .back_i      (back),
      .push_o      (push),
      .waddr_o     (waddr),
      .raddr_o     (raddr),
      .rdy_o       (core_rdy),
      .stop_o      (core_stop)
   );

   rpr_store #(.W(W), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .we_i    (push),
      .waddr_i (waddr),
      .wdata_i (src_data),
      .raddr_i (raddr),
      .rdata_o (core_rdata)
   );

   assign src_pop = push;

   always_ff @(posedge clk) begin
      if (!rst_n) occ_err <= 1'b0;
      else        occ_err <= bad;
   end
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
   parameter int W = 32
)(
   input logic         clk,
   input logic         rst_n,
   input logic         src_valid,
   input logic         src_pop,
   input logic         core_inc,
   input logic         core_last,
   input logic [1:0]   core_occ,
   input logic [W-1:0] core_rdata,
   input logic         core_rdy,
   input logic         core_stop,
   input logic         occ_err
);
   // R2
   pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> src_valid);

   // R6
   bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_last && core_occ == 2'b10) |=> occ_err);

   // R6
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_err |-> $past(core_last && core_occ == 2'b10));

   // R7
   stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop |-> (core_inc && !core_rdy && !src_valid));

   // R8
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rdy && !core_inc && !core_last) |=> (core_rdy && $stable(core_rdata)));

   // R4
   rdy_not_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rdy |-> !core_stop);
endmodule

bind np_read_rewind rpr_checker #(.W(W)) u_rpr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_valid  (src_valid),
   .src_pop    (src_pop),
   .core_inc   (core_inc),
   .core_last  (core_last),
   .core_occ   (core_occ),
   .core_rdata (core_rdata),
   .core_rdy   (core_rdy),
   .core_stop  (core_stop),
   .occ_err    (occ_err)
);

// File: tb/tb_np_read_rewind.sv
module tb_np_read_rewind;
   localparam int W     = 32;
   localparam int DEPTH = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic [W-1:0] src_data = '0;
   logic         src_pop;
   logic         core_inc = 1'b0;
   logic         core_last = 1'b0;
   logic [1:0]   core_occ = 2'b00;
   logic [W-1:0] core_rdata;
   logic         core_rdy, core_stop, occ_err;

   always #2 clk = ~clk;

   np_read_rewind #(.W(W), .DEPTH(DEPTH)) dut (.*);

   int total = 0;
   int bad = 0;
   bit done = 0;
   string dtag = "R3";

   logic [W-1:0] srcq[$];
   logic [W-1:0] mq[$];
   int  mrd = 0;
   bit  exp_err = 0;
   logic [W-1:0] next_word = 32'hA000_0000;

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic feed(int n);
      for (int i = 0; i < n; i++) begin
         srcq.push_back(next_word);
         next_word++;
      end
   endtask

   task automatic step(bit inc, bit last, logic [1:0] code);
      bit e_rdy, e_pop, e_stop, xfer;
      int r, nb;
      core_inc  = inc;
      core_last = last;
      core_occ  = code;
      src_valid = (srcq.size() > 0);
      src_data  = (srcq.size() > 0) ? srcq[0] : '0;
      #1;
      e_rdy  = (mrd < mq.size());
      e_pop  = (srcq.size() > 0) && (mq.size() < DEPTH);
      e_stop = inc && !e_rdy && (srcq.size() == 0);
      chk("R4", "core_rdy", W'(core_rdy), W'(e_rdy));
      chk("R2", "src_pop", W'(src_pop), W'(e_pop));
      chk("R7", "core_stop", W'(core_stop), W'(e_stop));
      chk("R6", "occ_err", W'(occ_err), W'(exp_err));
      if (e_rdy) chk(dtag, "core_rdata", core_rdata, mq[mrd]);
      xfer = inc && e_rdy;
      r = mrd + int'(xfer);
      if (last) begin
         nb = (code == 2'b11) ? 2 : (code == 2'b01) ? 1 : 0;
         r -= nb;
         for (int i = 0; i < r; i++) void'(mq.pop_front());
         mrd = 0;
         exp_err = (code == 2'b10);
      end else begin
         mrd = r;
         exp_err = 0;
      end
      if (e_pop) mq.push_back(srcq.pop_front());
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state with empty source
      chk("R1", "core_rdy", W'(core_rdy), 0);
      chk("R1", "core_stop", W'(core_stop), 0);
      chk("R1", "occ_err", W'(occ_err), 0);
      chk("R1", "src_pop", W'(src_pop), 0);
      @(negedge clk);

      // R7: request with nothing anywhere
      step(1, 0, 2'b00);
      step(0, 1, 2'b00);

      // R3 / R8: in-order delivery with wait gaps, then rewind by two (R5)
      feed(8);
      idle(3);
      dtag = "R3";
      step(1, 0, 2'b00);
      dtag = "R8";
      step(0, 0, 2'b00);
      step(0, 0, 2'b00);
      dtag = "R3";
      step(1, 0, 2'b00);
      step(1, 0, 2'b00);
      step(1, 1, 2'b11);
      dtag = "R5";
      step(1, 0, 2'b00);
      step(1, 0, 2'b00);
      step(1, 1, 2'b01);
      step(1, 0, 2'b00);
      step(0, 1, 2'b00);
      // R6: illegal code, no rewind
      dtag = "R6";
      step(1, 0, 2'b00);
      step(1, 1, 2'b10);
      step(1, 0, 2'b00);
      step(0, 1, 2'b00);
      // drain everything, R7 on empty buffer and source
      dtag = "R3";
      for (int i = 0; i < 6; i++) step(1, 0, 2'b00);
      step(0, 1, 2'b00);
      // R4: source becomes non-empty on a request cycle: wait, not stop
      feed(1);
      step(1, 0, 2'b00);
      step(1, 0, 2'b00);
      step(0, 1, 2'b00);
      // R2: fill to capacity, delivered dwords still held until last cycle
      feed(24);
      idle(20);
      for (int i = 0; i < 5; i++) step(1, 0, 2'b00);
      idle(3);
      dtag = "R5";
      step(0, 1, 2'b11);
      idle(6);
      dtag = "R3";
      for (int i = 0; i < 12; i++) step((i % 3) != 2, 0, 2'b00);
      step(1, 1, 2'b01);
      idle(4);
      for (int i = 0; i < 30; i++) step(1, 0, 2'b00);
      step(0, 1, 2'b00);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule